// File: doc/BRIEF.md
# Branch Condition Evaluator

This block decides whether a conditional branch is taken. It reads the four status flags left behind by an earlier ALU operation and a 5-bit condition code. Several kinds of test are supported:

- a single flag, tested for set or clear;
- unsigned relations, decoded from carry (acting as borrow) and zero after a subtraction A - B;
- signed relations, decoded from negative, overflow and zero after the same subtraction;
- equality and inequality;
- always and never.

The decision is registered together with the next program counter. That value is the effective address when the branch is taken, and the incremented PC otherwise.

A request is offered by raising `valid_i` for one cycle with the condition, flags and both candidate addresses. The result appears on the next clock with `valid_o` high. It stays on the outputs until the next request is accepted.

Top module: `branch_eval`

## Requirements
- R1: While `rst_ni` is low, `valid_o`, `taken_o` and `next_pc_o` are all zero.
- R2: A request sampled with `valid_i` high on a rising edge produces `valid_o` high for exactly that following cycle. No other cycle shows `valid_o` high.
- R3: On an edge where `valid_i` is low, `taken_o` and `next_pc_o` keep their previous values.
- R4: `next_pc_o` equals the `ea_i` of the request when taken, and its `pc_inc_i` when not taken.
- R5: Flags are packed as `flags_i[3]`=C, `[2]`=N, `[1]`=V, `[0]`=Z. The single-flag codes are 0: Z=1, 1: Z=0, 2: C=1, 3: C=0, 4: N=1, 5: N=0, 6: V=1, 7: V=0.
- R6: Code 8 (unsigned higher) is taken when C=0 and Z=0. Code 11 (unsigned lower or same) is taken when C=1 or Z=1.
- R7: Code 9 (unsigned higher or same) is taken when C=0. Code 10 (unsigned lower) is taken when C=1.
- R8: Code 14 (signed less) is taken when N xor V = 1. Code 13 (signed greater or equal) is taken when N xor V = 0.
- R9: Code 12 (signed greater) is taken when N xor V = 0 and Z=0. Code 15 (signed less or equal) is its complement.
- R10: Code 16 (equal) is taken when Z=1. Code 17 (not equal) is taken when Z=0.
- R11: Code 18 is always taken. Code 19 and the unused codes 20 to 31 are never taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Request strobe |
| cond_i | input | 5 | Condition code |
| flags_i | input | 4 | Status flags {C,N,V,Z} |
| pc_inc_i | input | ADDR_W | Incremented PC |
| ea_i | input | ADDR_W | Branch effective address |
| valid_o | output | 1 | Result strobe |
| taken_o | output | 1 | Branch decision |
| next_pc_o | output | ADDR_W | Selected next PC |

## Verification
Every result is due exactly one rising edge after the edge that samples its request. Outputs are held on all other edges.

The driver changes inputs on a falling edge and queues the expected decision and address. The monitor compares on the next falling edge, whenever `valid_o` is high. It checks that outputs are stable on every falling edge where `valid_o` is low, and a leftover or missing queue entry counts against the one-cycle latency.

All 32 codes are swept across all 16 flag combinations, with idle gaps mixed in.

// File: rtl/branch_pkg.sv
package branch_pkg;
  localparam int COND_W = 5;
  localparam int FLAG_W = 4;
  localparam int NUM_FLAG_TESTS = 2 * FLAG_W;
  localparam int NUM_REL = 10;

  // flag bit positions inside flags_i
  localparam int FB_Z = 0;
  localparam int FB_V = 1;
  localparam int FB_N = 2;
  localparam int FB_C = 3;

  typedef enum logic [COND_W-1:0] {
    C_ZSET  = 5'd0,  C_ZCLR  = 5'd1,
    C_CSET  = 5'd2,  C_CCLR  = 5'd3,
    C_NSET  = 5'd4,  C_NCLR  = 5'd5,
    C_VSET  = 5'd6,  C_VCLR  = 5'd7,
    C_UHI   = 5'd8,  C_UHS   = 5'd9,
    C_ULO   = 5'd10, C_ULS   = 5'd11,
    C_SGT   = 5'd12, C_SGE   = 5'd13,
    C_SLT   = 5'd14, C_SLE   = 5'd15,
    C_EQ    = 5'd16, C_NE    = 5'd17,
    C_ALW   = 5'd18, C_NEVER = 5'd19
  } cond_e;

  localparam logic [COND_W-1:0] REL_BASE = 5'd8;

  // flag index tested by single-flag slot i (order Z, C, N, V)
  function automatic int flag_of_slot(input int slot);
    case (slot)
      0: return FB_Z;
      1: return FB_C;
      2: return FB_N;
      default: return FB_V;
    endcase
  endfunction
endpackage

// File: rtl/branch_flag_test.sv
module branch_flag_test
  import branch_pkg::*;
(
  input  logic [FLAG_W-1:0]         flags_i,
  output logic [NUM_FLAG_TESTS-1:0] hit_o
);
  for (genvar i = 0; i < FLAG_W; i++) begin : g_slot
    localparam int FIDX = flag_of_slot(i);
    assign hit_o[2*i]   =  flags_i[FIDX];
    assign hit_o[2*i+1] = ~flags_i[FIDX];
  end
endmodule

// File: rtl/branch_rel_test.sv
module branch_rel_test
  import branch_pkg::*;
(
  input  logic [FLAG_W-1:0]  flags_i,
  output logic [NUM_REL-1:0] rel_o
);
  logic c, n, v, z, lt_s, hi_u;

  assign c = flags_i[FB_C];
  assign n = flags_i[FB_N];
  assign v = flags_i[FB_V];
  assign z = flags_i[FB_Z];

  assign lt_s = n ^ v;
  assign hi_u = ~c & ~z;

  // bit k corresponds to code REL_BASE + k
  always_comb begin
    rel_o = '0;
    rel_o[C_UHI - REL_BASE] = hi_u;
    rel_o[C_UHS - REL_BASE] = ~c;
    rel_o[C_ULO - REL_BASE] = c;
    rel_o[C_ULS - REL_BASE] = ~hi_u;
    rel_o[C_SGT - REL_BASE] = ~lt_s & ~z;
    rel_o[C_SGE - REL_BASE] = ~lt_s;
    rel_o[C_SLT - REL_BASE] = lt_s;
    rel_o[C_SLE - REL_BASE] = lt_s | z;
    rel_o[C_EQ  - REL_BASE] = z;
    rel_o[C_NE  - REL_BASE] = ~z;
  end
endmodule

// File: rtl/branch_cond_mux.sv
module branch_cond_mux
  import branch_pkg::*;
(
  input  logic [COND_W-1:0]         cond_i,
  input  logic [NUM_FLAG_TESTS-1:0] hit_i,
  input  logic [NUM_REL-1:0]        rel_i,
  output logic                      taken_o
);
  localparam int REL_END = int'(REL_BASE) + NUM_REL;

  always_comb begin
    taken_o = 1'b0;
    if (int'(cond_i) < NUM_FLAG_TESTS)
      taken_o = hit_i[cond_i[$clog2(NUM_FLAG_TESTS)-1:0]];
    else if (int'(cond_i) < REL_END)
      taken_o = rel_i[4'(cond_i - REL_BASE)];
    else if (cond_i == C_ALW)
      taken_o = 1'b1;
  end
endmodule

// File: rtl/branch_eval.sv
module branch_eval
  import branch_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic [4:0]        cond_i,
  input  logic [3:0]        flags_i,
  input  logic [ADDR_W-1:0] pc_inc_i,
  input  logic [ADDR_W-1:0] ea_i,
  output logic              valid_o,
  output logic              taken_o,
  output logic [ADDR_W-1:0] next_pc_o
);
  logic [NUM_FLAG_TESTS-1:0] hit;
  logic [NUM_REL-1:0]        rel;
  logic                      take_d;

  branch_flag_test u_flag (.flags_i(flags_i), .hit_o(hit));
  branch_rel_test  u_rel  (.flags_i(flags_i), .rel_o(rel));
  branch_cond_mux  u_mux  (.cond_i(cond_i), .hit_i(hit), .rel_i(rel), .taken_o(take_d));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o   <= 1'b0;
      taken_o   <= 1'b0;
      next_pc_o <= '0;
    end else begin
      valid_o <= valid_i;
      if (valid_i) begin
        taken_o   <= take_d;
        next_pc_o <= take_d ? ea_i : pc_inc_i;
      end
    end
  end
endmodule

// File: rtl/branch_eval_chk.sv
module branch_eval_chk
  import branch_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              valid_i,
  input logic [4:0]        cond_i,
  input logic [3:0]        flags_i,
  input logic [ADDR_W-1:0] pc_inc_i,
  input logic [ADDR_W-1:0] ea_i,
  input logic              valid_o,
  input logic              taken_o,
  input logic [ADDR_W-1:0] next_pc_o
);
  logic armed;
  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) armed <= 1'b0;
    else         armed <= 1'b1;

  // R1
  always_comb if (!rst_ni) reset_state_chk: assert (!valid_o && !taken_o && next_pc_o == '0);

  // R2
  valid_delay_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    armed |-> valid_o == $past(valid_i));

  // R3
  hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (armed && !$past(valid_i)) |-> ($stable(taken_o) && $stable(next_pc_o)));

  // R4
  next_pc_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (armed && valid_o) |-> next_pc_o == (taken_o ? $past(ea_i) : $past(pc_inc_i)));

  // R6
  unsigned_hi_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (armed && valid_o && $past(cond_i) == C_UHI) |->
      taken_o == (!$past(flags_i[FB_C]) && !$past(flags_i[FB_Z])));

  // R8
  signed_lt_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (armed && valid_o && $past(cond_i) == C_SLT) |->
      taken_o == ($past(flags_i[FB_N]) ^ $past(flags_i[FB_V])));

  // R11
  always_taken_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (armed && valid_o && $past(cond_i) == C_ALW) |-> taken_o);

  // R11
  never_taken_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (armed && valid_o && $past(cond_i) >= C_NEVER) |-> !taken_o);
endmodule

bind branch_eval branch_eval_chk #(.ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/branch_eval_bench.sv
module branch_eval_bench;
  localparam int AW = 16;

  typedef struct {
    logic          taken;
    logic [AW-1:0] pc;
    string         req;
  } exp_t;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          valid_i = 1'b0;
  logic [4:0]    cond_i = '0;
  logic [3:0]    flags_i = '0;
  logic [AW-1:0] pc_inc_i = '0;
  logic [AW-1:0] ea_i = '0;
  logic          valid_o, taken_o;
  logic [AW-1:0] next_pc_o;

  int   total = 0;
  int   bad = 0;
  exp_t sb[$];
  logic have_last = 1'b0;
  logic last_taken;
  logic [AW-1:0] last_pc;
  bit   done = 1'b0;

  always #10 clk = ~clk;

  branch_eval #(.ADDR_W(AW)) u_branch_eval (
    .clk_i(clk), .rst_ni(rst_n), .valid_i(valid_i), .cond_i(cond_i),
    .flags_i(flags_i), .pc_inc_i(pc_inc_i), .ea_i(ea_i),
    .valid_o(valid_o), .taken_o(taken_o), .next_pc_o(next_pc_o));

  task automatic check(input bit ok, input string req, input string what,
                       input logic [AW-1:0] act, input logic [AW-1:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // expected decision from requirement text; flags {C,N,V,Z}
  function automatic logic model(input int code, input logic [3:0] f);
    logic c, n, v, z;
    {c, n, v, z} = f;
    case (code)
      0: return z;        1: return !z;      // R5
      2: return c;        3: return !c;
      4: return n;        5: return !n;
      6: return v;        7: return !v;
      8: return !c && !z; 11: return c || z; // R6
      9: return !c;       10: return c;      // R7
      14: return n ^ v;   13: return !(n ^ v); // R8
      12: return !(n ^ v) && !z; 15: return (n ^ v) || z; // R9
      16: return z;       17: return !z;     // R10
      18: return 1'b1;                       // R11
      default: return 1'b0;
    endcase
  endfunction

  function automatic string req_of(input int code);
    if (code < 8) return "R5";
    if (code == 8 || code == 11) return "R6";
    if (code == 9 || code == 10) return "R7";
    if (code == 13 || code == 14) return "R8";
    if (code == 12 || code == 15) return "R9";
    if (code == 16 || code == 17) return "R10";
    return "R11";
  endfunction

  task automatic send(input int code, input logic [3:0] f);
    exp_t e;
    logic [AW-1:0] pc, ea;
    pc = AW'($urandom);
    ea = pc ^ 16'h8421;
    @(negedge clk);
    valid_i  = 1'b1;
    cond_i   = 5'(code);
    flags_i  = f;
    pc_inc_i = pc;
    ea_i     = ea;
    e.taken  = model(code, f);
    e.pc     = e.taken ? ea : pc;
    e.req    = req_of(code);
    sb.push_back(e);
  endtask

  task automatic idle();
    @(negedge clk);
    valid_i  = 1'b0;
    cond_i   = 5'd18;
    flags_i  = 4'($urandom);
    pc_inc_i = AW'($urandom);
    ea_i     = AW'($urandom);
  endtask

  // monitor: results due one edge after the request
  always @(negedge clk) begin
    if (rst_n && !done) begin
      if (valid_o) begin
        if (sb.size() == 0) begin
          check(1'b0, "R2", "unexpected valid_o", 1, 0);
        end else begin
          exp_t e;
          e = sb.pop_front();
          check(taken_o == e.taken, e.req, "taken_o", AW'(taken_o), AW'(e.taken));
          check(next_pc_o == e.pc, "R4", "next_pc_o", next_pc_o, e.pc);
        end
        last_taken = taken_o;
        last_pc    = next_pc_o;
        have_last  = 1'b1;
      end else if (have_last) begin
        // R3: hold across idle edges
        check(taken_o == last_taken && next_pc_o == last_pc, "R3", "held next_pc_o",
              next_pc_o, last_pc);
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check(!valid_o && !taken_o && next_pc_o == '0, "R1", "reset outputs",
          next_pc_o, '0);
    rst_n = 1'b1;
    last_taken = 1'b0;
    last_pc = '0;
    have_last = 1'b1;
    idle();
    for (int code = 0; code < 32; code++) begin
      for (int f = 0; f < 16; f++) begin
        send(code, 4'(f));
        if ((f % 5) == 4) begin
          idle();
          idle();
        end
      end
    end
    idle();
    idle();
    check(sb.size() == 0, "R2", "missing results", AW'(sb.size()), '0);
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      total++;
      bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule